// File: doc/BRIEF.md
# ALU Bundle Assembler for a Five-Lane Scalar Group

This block collects a stream of 64-bit instruction words and builds one issue bundle for a group of five scalar lanes plus a separate branch unit. A bundle is made of one or more operation words, closed by a word carrying a last-op flag. That closing word also states how many literal-constant words (zero to two) follow it. Once the final word of a bundle has been accepted, the block presents the complete bundle: per-lane enables with the operation word routed to each lane, the literal words in arrival order with their count, the branch operation on its own port, and a conflict flag.

Only one lane (lane 4) can execute transcendental operations. General math, integer and bitwise operations take the lowest free lane other than lane 4, and use lane 4 only when every other lane is full. A transcendental operation that finds lane 4 taken cannot be placed, so the bundle is marked as conflicting. Malformed bundles are dropped and reported with a one-cycle error pulse. The input uses a valid/ready handshake that stalls while a finished bundle waits for its consumer.

Top module: `alu_bundle_builder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and out_err is 0.
- R2: Op word fields are bit 63 = last-op flag, bits 62:61 = number of literal words that follow (read from the last op word only), and bits 60:59 = class (0 math, 1 transcendental, 2 branch, 3 integer/bitwise). A bundle is complete when its last op word (literal count 0) or its final literal word is accepted, and out_valid rises in the next cycle.
- R3: A math or integer/bitwise op is placed in the lowest-numbered free lane other than lane 4. It takes lane 4 only when lanes 0 to 3 are all occupied. out_lane_en shows the occupied lanes.
- R4: A transcendental op is placed in lane 4, and each enabled lane's out_lane_op carries the accepted op word placed there.
- R5: A branch-class op occupies no lane. It sets out_br_valid, and out_br_op carries that word.
- R6: The literal words that follow the last op word appear on out_lit slot 0 then slot 1 in arrival order, and out_lit_cnt gives their number (0 to 2).
- R7: out_conflict is set on the delivered bundle, and the offending op is not placed, when a transcendental op finds lane 4 occupied, a lane op finds all five lanes occupied, or a second branch op arrives. The first branch op is kept.
- R8: A last op word with literal count 3, a last op word whose bundle would exceed 7 words in total, or a sixth op word without the last-op flag drops the bundle. out_err pulses for one cycle after that word, no bundle is delivered, and the next word starts a new bundle.
- R9: in_ready is 0 while out_valid is 1. A delivered bundle stays unchanged until out_ready is seen, and out_valid falls in the cycle after that.
- R10: Bundles of the maximum length of 7 words (5 ops + 2 literals, or 6 ops including a branch + 1 literal) are accepted and delivered whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 64 | Op or literal word |
| out_valid | output | 1 | Complete bundle available |
| out_ready | input | 1 | Consumer takes the bundle |
| out_lane_en | output | 5 | Lane occupied in this bundle |
| out_lane_op | output | 5x64 | Op word routed to each lane |
| out_lit | output | 2x64 | Literal words, slot 0 first |
| out_lit_cnt | output | 2 | Number of valid literal slots |
| out_br_valid | output | 1 | Bundle carries a branch op |
| out_br_op | output | 64 | Branch op word |
| out_conflict | output | 1 | Slot rule broken in this bundle |
| out_err | output | 1 | One-cycle pulse: bundle dropped |

## Verification
The hardest cases are the ones that need a full lane set before the critical word arrives. Examples are a fifth math op spilling into lane 4 just ahead of a transcendental op, and a sixth op word arriving without its last flag. Random word classes rarely line these up, so directed bundles build them word by word. Random bundles with random input gaps and consumer stalls then run on top. Malformed bundles in the random stream also check that the word after a dropped bundle is taken as the start of a new one.

// File: rtl/bndl_pkg.sv
package bndl_pkg;

    localparam int HDR_W = 5;

    typedef enum logic [1:0] {
        CLS_MATH   = 2'd0,
        CLS_TRANS  = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_INTBIT = 2'd3
    } op_class_e;

    typedef struct packed {
        logic      last;
        logic [1:0] lit_cnt;
        op_class_e cls;
    } op_hdr_t;

    typedef enum logic {
        PH_OPS  = 1'b0,
        PH_LITS = 1'b1
    } phase_e;

    // top bits of a word: {last, lit_cnt[1:0], cls[1:0]}
    function automatic op_hdr_t decode_hdr(input logic [HDR_W-1:0] top);
        op_hdr_t h;
        h.last    = top[4];
        h.lit_cnt = top[3:2];
        h.cls     = op_class_e'(top[1:0]);
        return h;
    endfunction

endpackage

// File: rtl/bndl_lane_pick.sv
module bndl_lane_pick #(
    parameter int NLANES = 5,
    parameter int TLANE  = 4
) (
    input  logic [NLANES-1:0] occ,
    input  logic              want,
    input  logic              is_trans,
    output logic [NLANES-1:0] grant,
    output logic              blocked
);
    logic [NLANES-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NLANES - 1; i >= 0; i--) begin
            if (i != TLANE && !occ[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_comb begin
        grant   = '0;
        blocked = 1'b0;
        if (want) begin
            if (!is_trans && pick != '0) begin
                grant = pick;
            end else if (!occ[TLANE]) begin
                grant[TLANE] = 1'b1;
            end else begin
                blocked = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bndl_seq.sv
module bndl_seq
    import bndl_pkg::*;
#(
    parameter int MAX_OPS   = 6,
    parameter int MAX_LIT   = 2,
    parameter int MAX_WORDS = 7,
    localparam int OCW = $clog2(MAX_OPS + 1),
    localparam int LIW = $clog2(MAX_LIT + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic           last,
    input  logic [1:0]     litc,
    output logic           in_ops,
    output logic           first_op,
    output logic           bad,
    output logic           close,
    output logic [LIW-1:0] lit_idx
);
    phase_e         phase;
    logic [OCW-1:0] op_cnt;
    logic [LIW-1:0] lit_need;

    always_comb begin
        in_ops   = (phase == PH_OPS);
        first_op = in_ops && (op_cnt == '0);
        if (last)
            bad = in_ops && ((int'(litc) > MAX_LIT) ||
                             (int'(op_cnt) + 1 + int'(litc) > MAX_WORDS));
        else
            bad = in_ops && (int'(op_cnt) + 1 >= MAX_OPS);
        if (in_ops)
            close = take && last && (litc == 2'd0) && !bad;
        else
            close = take && (lit_idx == lit_need - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPS;
            op_cnt   <= '0;
            lit_need <= '0;
            lit_idx  <= '0;
        end else if (take) begin
            if (in_ops) begin
                if (bad || last) op_cnt <= '0;
                else             op_cnt <= op_cnt + 1'b1;
                if (!bad && last && litc != 2'd0) begin
                    phase    <= PH_LITS;
                    lit_need <= LIW'(litc);
                    lit_idx  <= '0;
                end
            end else begin
                lit_idx <= lit_idx + 1'b1;
                if (close) phase <= PH_OPS;
            end
        end
    end
endmodule

// File: rtl/alu_bundle_builder.sv
module alu_bundle_builder
    import bndl_pkg::*;
#(
    parameter int NLANES    = 5,
    parameter int TLANE     = 4,
    parameter int W         = 64,
    parameter int MAX_LIT   = 2,
    parameter int MAX_WORDS = 7,
    parameter int MAX_OPS   = NLANES + 1,
    localparam int LIW = $clog2(MAX_LIT + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [W-1:0]               in_word,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NLANES-1:0]          out_lane_en,
    output logic [NLANES-1:0][W-1:0]   out_lane_op,
    output logic [MAX_LIT-1:0][W-1:0]  out_lit,
    output logic [LIW-1:0]             out_lit_cnt,
    output logic                       out_br_valid,
    output logic [W-1:0]               out_br_op,
    output logic                       out_conflict,
    output logic                       out_err
);
    op_hdr_t           hdr;
    logic              take, in_ops, first_op, bad, close, keep;
    logic              is_br, br_dup, blocked;
    logic [LIW-1:0]    lit_idx;
    logic [NLANES-1:0] occ_eff, grant;

    assign hdr      = decode_hdr(in_word[W-1 -: HDR_W]);
    assign in_ready = !out_valid;
    assign take     = in_valid && in_ready;
    assign keep     = take && in_ops && !bad;
    assign is_br    = (hdr.cls == CLS_BRANCH);
    assign occ_eff  = first_op ? '0 : out_lane_en;
    assign br_dup   = keep && is_br && !first_op && out_br_valid;

    bndl_seq #(
        .MAX_OPS(MAX_OPS), .MAX_LIT(MAX_LIT), .MAX_WORDS(MAX_WORDS)
    ) u_seq (
        .clk(clk), .rst(rst), .take(take), .last(hdr.last), .litc(hdr.lit_cnt),
        .in_ops(in_ops), .first_op(first_op), .bad(bad), .close(close),
        .lit_idx(lit_idx)
    );

    bndl_lane_pick #(.NLANES(NLANES), .TLANE(TLANE)) u_pick (
        .occ(occ_eff), .want(keep && !is_br), .is_trans(hdr.cls == CLS_TRANS),
        .grant(grant), .blocked(blocked)
    );

    // control state
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_lane_en  <= '0;
            out_br_valid <= 1'b0;
            out_conflict <= 1'b0;
            out_lit_cnt  <= '0;
            out_err      <= 1'b0;
        end else begin
            out_err <= take && in_ops && bad;
            if (close)          out_valid <= 1'b1;
            else if (out_ready) out_valid <= 1'b0;
            if (keep) begin
                out_lane_en  <= occ_eff | grant;
                out_conflict <= (first_op ? 1'b0 : out_conflict) | blocked | br_dup;
                out_br_valid <= is_br | (first_op ? 1'b0 : out_br_valid);
                if (hdr.last) out_lit_cnt <= LIW'(hdr.lit_cnt);
            end
        end
    end

    // datapath storage
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (grant[g]) out_lane_op[g] <= in_word;
        end
    end

    for (genvar k = 0; k < MAX_LIT; k++) begin : g_lit
        always_ff @(posedge clk) begin
            if (take && !in_ops && lit_idx == LIW'(k)) out_lit[k] <= in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (keep && is_br && (first_op || !out_br_valid)) out_br_op <= in_word;
    end
endmodule

// File: rtl/bndl_checker.sv
module bndl_checker #(
    parameter int NLANES  = 5,
    parameter int MAX_LIT = 2,
    localparam int LIW = $clog2(MAX_LIT + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [NLANES-1:0] out_lane_en,
    input logic [LIW-1:0]    out_lit_cnt,
    input logic              out_br_valid,
    input logic              out_conflict,
    input logic              out_err
);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_lane_en) &&
            $stable(out_lit_cnt) && $stable(out_br_valid) && $stable(out_conflict));

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> !out_valid);

    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        out_err |-> !out_valid);

    p_lit_max_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(out_lit_cnt) <= MAX_LIT);

    p_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lane_en != '0) || out_br_valid);
endmodule

bind alu_bundle_builder bndl_checker #(.NLANES(NLANES), .MAX_LIT(MAX_LIT)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_en(out_lane_en), .out_lit_cnt(out_lit_cnt),
    .out_br_valid(out_br_valid), .out_conflict(out_conflict), .out_err(out_err)
);

// File: tb/alu_bundle_builder_test.sv
module alu_bundle_builder_test;
    localparam int NL = 5;
    localparam int TL = 4;
    localparam int W  = 64;
    localparam int ML = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                    in_valid = 1'b0, out_ready = 1'b0;
    logic [W-1:0]            in_word = '0;
    logic                    in_ready, out_valid, out_br_valid, out_conflict, out_err;
    logic [NL-1:0]           out_lane_en;
    logic [NL-1:0][W-1:0]    out_lane_op;
    logic [ML-1:0][W-1:0]    out_lit;
    logic [1:0]              out_lit_cnt;
    logic [W-1:0]            out_br_op;

    alu_bundle_builder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_lane_en(out_lane_en), .out_lane_op(out_lane_op), .out_lit(out_lit),
        .out_lit_cnt(out_lit_cnt), .out_br_valid(out_br_valid),
        .out_br_op(out_br_op), .out_conflict(out_conflict), .out_err(out_err)
    );

    int vectors = 0, errs = 0, tagc = 1;
    bit done = 0;
    int gap_pct = 0, stall_pct = 0;

    // reference model state
    logic [W-1:0] stim[$], pend_ops[$], pend_lits[$];
    bit           m_valid = 0, m_err = 0, m_inlits = 0, m_conf = 0, m_brv = 0;
    int           m_need = 0, m_litcnt = 0;
    bit           m_en[NL];
    logic [W-1:0] m_op[NL], m_lit[ML], m_br;

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] mk(bit last, int lc, int cls);
        logic [W-1:0] w;
        w = {last, 2'(lc), 2'(cls), 59'(tagc)};
        tagc++;
        return w;
    endfunction

    task automatic build();
        m_conf = 0;
        m_brv  = 0;
        for (int i = 0; i < NL; i++) m_en[i] = 0;
        foreach (pend_ops[k]) begin
            logic [W-1:0] w = pend_ops[k];
            int c = int'(w[60:59]);
            bit placed = 0;
            if (c == 2) begin
                if (m_brv) m_conf = 1;
                else begin m_brv = 1; m_br = w; end
            end else begin
                if (c != 1) begin
                    for (int i = 0; i < NL; i++)
                        if (i != TL && !m_en[i] && !placed) begin
                            m_en[i] = 1; m_op[i] = w; placed = 1;
                        end
                end
                if (!placed) begin
                    if (!m_en[TL]) begin m_en[TL] = 1; m_op[TL] = w; end
                    else m_conf = 1;
                end
            end
        end
        foreach (pend_lits[k]) m_lit[k] = pend_lits[k];
        m_valid = 1;
        pend_ops.delete();
        pend_lits.delete();
    endtask

    task automatic step(bit acc, logic [W-1:0] w, bit ordy);
        m_err = 0;
        if (m_valid && ordy) m_valid = 0;
        if (acc) begin
            if (!m_inlits) begin
                int n, lc;
                pend_ops.push_back(w);
                n  = pend_ops.size();
                lc = int'(w[62:61]);
                if (w[63] ? (lc > 2 || n + lc > 7) : (n >= 6)) begin
                    m_err = 1;
                    pend_ops.delete();
                end else if (w[63]) begin
                    m_litcnt = lc;
                    if (lc == 0) build();
                    else begin m_inlits = 1; m_need = lc; end
                end
            end else begin
                pend_lits.push_back(w);
                if (pend_lits.size() == m_need) begin
                    m_inlits = 0;
                    build();
                end
            end
        end
    endtask

    task automatic compare();
        logic [NL-1:0] en;
        chk("R9", "in_ready", W'(in_ready), W'(!m_valid));
        chk("R2", "out_valid", W'(out_valid), W'(m_valid));
        chk("R8", "out_err", W'(out_err), W'(m_err));
        if (m_valid) begin
            for (int i = 0; i < NL; i++) en[i] = m_en[i];
            chk("R3 R10", "lane_en", W'(out_lane_en), W'(en));
            for (int i = 0; i < NL; i++)
                if (m_en[i]) chk("R4", $sformatf("lane_op[%0d]", i), out_lane_op[i], m_op[i]);
            chk("R6 R10", "lit_cnt", W'(out_lit_cnt), W'(m_litcnt));
            for (int k = 0; k < m_litcnt; k++)
                chk("R6", $sformatf("lit[%0d]", k), out_lit[k], m_lit[k]);
            chk("R5", "br_valid", W'(out_br_valid), W'(m_brv));
            if (m_brv) chk("R5", "br_op", out_br_op, m_br);
            chk("R7", "conflict", W'(out_conflict), W'(m_conf));
        end
    endtask

    task automatic run(int maxc);
        for (int c = 0; c < maxc; c++) begin
            bit acc;
            @(negedge clk);
            compare();
            if (stim.size() == 0 && !m_valid && !m_err) break;
            in_valid  = (stim.size() > 0) && ($urandom_range(99) >= gap_pct);
            in_word   = (stim.size() > 0) ? stim[0] : '0;
            out_ready = ($urandom_range(99) >= stall_pct);
            @(posedge clk);
            acc = in_valid && !m_valid;
            if (acc) void'(stim.pop_front());
            step(acc, in_word, out_ready);
        end
        in_valid = 1'b0;
    endtask

    task automatic push_ops(int n, int cls, int lc);
        for (int i = 0; i < n; i++) stim.push_back(mk(i == n - 1, lc, cls));
    endtask

    task automatic push_lits(int n);
        for (int i = 0; i < n; i++) stim.push_back({5'b0, 59'(tagc++)} ^ 64'hA5A5_0000_0000_5A5A);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL R2 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset out_valid", W'(out_valid), '0);
        chk("R1", "reset in_ready", W'(in_ready), W'(1));
        chk("R1", "reset out_err", W'(out_err), '0);
        rst = 1'b0;

        // R2 single op; R4 trans with literal; R10 five math + two literals
        stim.push_back(mk(1, 0, 0));
        stim.push_back(mk(0, 0, 0)); stim.push_back(mk(0, 0, 3));
        stim.push_back(mk(0, 0, 0)); stim.push_back(mk(1, 1, 1)); push_lits(1);
        push_ops(5, 0, 2); push_lits(2);
        run(200);
        // R5 branch routing, branch-only bundle
        stim.push_back(mk(0, 0, 2)); stim.push_back(mk(0, 0, 0));
        stim.push_back(mk(0, 0, 3)); stim.push_back(mk(1, 0, 1));
        stim.push_back(mk(1, 0, 2));
        // R7 two trans; lane 4 spilled then trans; six math; two branches
        stim.push_back(mk(0, 0, 1)); stim.push_back(mk(1, 0, 1));
        push_ops(5, 3, 0); stim[$][63] = 1'b0; stim.push_back(mk(1, 0, 1));
        push_ops(6, 0, 0);
        stim.push_back(mk(0, 0, 2)); stim.push_back(mk(1, 1, 2)); push_lits(1);
        stall_pct = 70;
        run(400);
        // R8 literal count 3; sixth op not last; 6 ops + 2 literals; then recovery
        stall_pct = 0;
        stim.push_back(mk(1, 3, 0));
        push_ops(6, 0, 0); stim[$][63] = 1'b0; stim.push_back(mk(1, 0, 1));
        push_ops(6, 3, 2);
        push_lits(2);
        // R10 branch + five math + one literal
        stim.push_back(mk(0, 0, 2)); push_ops(5, 0, 1); push_lits(1);
        run(400);

        // random bundles with gaps and stalls
        gap_pct = 25;
        stall_pct = 40;
        for (int b = 0; b < 300; b++) begin
            int n  = $urandom_range(6, 1);
            int lc = ($urandom_range(9) == 0) ? 3 : $urandom_range(2);
            for (int i = 0; i < n; i++)
                stim.push_back(mk(i == n - 1 && $urandom_range(19) != 0, lc,
                                  $urandom_range(3)));
            if (lc < 3) push_lits(lc);
        end
        run(20000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule